// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Bank

This block decides, for each frame that the CAN protocol engine has received, whether the frame goes into the receive FIFO. The engine presents the 29-bit identifier, the IDE bit and the RTR bit, together with a one-cycle strobe. One clock later the block returns a decision: accept or reject. When it accepts, it also issues a store strobe to the receive FIFO. Rejected frames have already been acknowledged on the bus by the engine, so the block only drops them.

A parameter sets the number of filters, from zero to four. Each filter holds a mask word and a reference word in the same 31-bit key layout as the frame. Software writes the per-filter enables as one word. A frame passes when any enabled filter matches it. With no filter enabled, or with no filters built, every frame passes. A mask or reference can be rewritten only while its filter is disabled, so an enabled filter never compares against a half-updated pair.

Top module: `can_accept_filter`

## Requirements
- R1: After synchronous reset, `dec_vld`, `dec_acc` and `st_wr` are low, all filters are disabled, and all mask and reference words are zero.
- R2: The key is {IDE at bit 30, RTR at bit 29, identifier at bits 28:0}. A filter hits when the key equals its reference word in every bit where its mask word is 1. Bits where the mask is 0 do not matter.
- R3: A frame is accepted when at least one enabled filter hits, and rejected when all enabled filters miss.
- R4: When the enable word is all zero, or when `NUM_FLT` is 0, every frame is accepted.
- R5: `dec_vld` is high exactly in the cycle after each `frm_vld` cycle, back-to-back strobes included. `dec_acc` is low whenever `dec_vld` is low.
- R6: `st_wr` is high in the cycle after the strobe only when the frame is accepted and `fifo_nfull` was high in the strobe cycle.
- R7: A rejected frame gives `dec_vld` high with `dec_acc` low, and never gives `st_wr`.
- R8: A write with `cfg_wr` goes to the mask word (`cfg_sel`=0) or the reference word (`cfg_sel`=1) of filter `cfg_idx`. It takes effect only if that filter is disabled at the time of the write, and is ignored otherwise.
- R9: `en_wr` loads the whole enable word from `en_wdata`, bit i enabling filter i. Bits for filters at or above `NUM_FLT` have no effect.
- R10: Because IDE and RTR are part of the key, a standard frame and an extended frame with the same low identifier bits are told apart, as are data frames and remote frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_vld | input | 1 | Received-frame strobe, one cycle per frame |
| frm_id | input | 29 | Received identifier (standard IDs in bits 10:0) |
| frm_ide | input | 1 | Extended-format flag of the frame |
| frm_rtr | input | 1 | Remote-request flag of the frame |
| fifo_nfull | input | 1 | Receive FIFO has room |
| cfg_wr | input | 1 | Mask or reference write strobe |
| cfg_idx | input | 2 | Filter index of the write |
| cfg_sel | input | 1 | 0 selects the mask word, 1 selects the reference word |
| cfg_wdata | input | 31 | Write data in key layout |
| en_wr | input | 1 | Enable-word write strobe |
| en_wdata | input | 4 | New enable word |
| dec_vld | output | 1 | Decision valid |
| dec_acc | output | 1 | Frame accepted |
| st_wr | output | 1 | Store strobe to the receive FIFO |

## Verification
The bench builds two copies. The main copy uses `NUM_FLT`=4, which exercises exact matches, partial masks, masks on only the flag bits, and OR-ing of several filters. It also exercises ignored writes to enabled filters, rewrites after disabling, an all-zero enable word, and a full FIFO. The second copy uses `NUM_FLT`=0, the variant in which no filter logic takes part. It shows that every frame is stored even after every enable bit is written high.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;
  localparam int MAX_FLT = 4;
  localparam int ID_W    = 29;
  localparam int KEY_W   = ID_W + 2;
  localparam int IDX_W   = $clog2(MAX_FLT);
  localparam int IDE_BIT = KEY_W - 1;
  localparam int RTR_BIT = KEY_W - 2;

  typedef logic [KEY_W-1:0] key_t;

  function automatic key_t make_key(input logic ide, input logic rtr,
                                    input logic [ID_W-1:0] id);
    return {ide, rtr, id};
  endfunction
endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
  import can_flt_pkg::*;
#(
  parameter int NUM_FLT = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_wr,
  input  logic [IDX_W-1:0]               cfg_idx,
  input  logic                           cfg_sel,
  input  logic [KEY_W-1:0]               cfg_wdata,
  input  logic                           en_wr,
  input  logic [MAX_FLT-1:0]             en_wdata,
  output logic [MAX_FLT-1:0][KEY_W-1:0]  mask_o,
  output logic [MAX_FLT-1:0][KEY_W-1:0]  ref_o,
  output logic [MAX_FLT-1:0]             en_o
);
  for (genvar g = 0; g < MAX_FLT; g++) begin : g_flt
    if (g < NUM_FLT) begin : g_live
      logic [KEY_W-1:0] mask_q, ref_q;
      logic             en_q;
      logic             hit_idx;
      assign hit_idx = cfg_wr && (cfg_idx == IDX_W'(g)) && !en_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          mask_q <= '0;
          ref_q  <= '0;
          en_q   <= 1'b0;
        end else begin
          if (en_wr) en_q <= en_wdata[g];
          if (hit_idx) begin
            if (cfg_sel) ref_q  <= cfg_wdata;
            else         mask_q <= cfg_wdata;
          end
        end
      end
      assign mask_o[g] = mask_q;
      assign ref_o[g]  = ref_q;
      assign en_o[g]   = en_q;
    end else begin : g_absent
      assign mask_o[g] = '0;
      assign ref_o[g]  = '0;
      assign en_o[g]   = 1'b0;
    end
  end
endmodule

// File: rtl/can_flt_match.sv
module can_flt_match
  import can_flt_pkg::*;
(
  input  logic [KEY_W-1:0] key,
  input  logic [KEY_W-1:0] mask,
  input  logic [KEY_W-1:0] ref_key,
  output logic             hit
);
  always_comb hit = ~|((key ^ ref_key) & mask);
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_flt_pkg::*;
#(
  parameter int NUM_FLT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_vld,
  input  logic [ID_W-1:0]    frm_id,
  input  logic               frm_ide,
  input  logic               frm_rtr,
  input  logic               fifo_nfull,
  input  logic               cfg_wr,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_sel,
  input  logic [KEY_W-1:0]   cfg_wdata,
  input  logic               en_wr,
  input  logic [MAX_FLT-1:0] en_wdata,
  output logic               dec_vld,
  output logic               dec_acc,
  output logic               st_wr
);
  logic [MAX_FLT-1:0][KEY_W-1:0] mask_w, ref_w;
  logic [MAX_FLT-1:0]            en_w, hit_w;
  key_t                          key;
  logic                          pass;

  assign key = make_key(frm_ide, frm_rtr, frm_id);

  can_flt_regs #(.NUM_FLT(NUM_FLT)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .en_wr(en_wr),
    .en_wdata(en_wdata), .mask_o(mask_w), .ref_o(ref_w), .en_o(en_w)
  );

  if (NUM_FLT == 0) begin : g_nofilt
    assign hit_w = '0;
    assign pass  = 1'b1;
  end else begin : g_filt
    for (genvar g = 0; g < MAX_FLT; g++) begin : g_cmp
      can_flt_match u_match (
        .key(key), .mask(mask_w[g]), .ref_key(ref_w[g]), .hit(hit_w[g])
      );
    end
    assign pass = (en_w == '0) || (|(hit_w & en_w));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_vld <= 1'b0;
      dec_acc <= 1'b0;
      st_wr   <= 1'b0;
    end else begin
      dec_vld <= frm_vld;
      dec_acc <= frm_vld && pass;
      st_wr   <= frm_vld && pass && fifo_nfull;
    end
  end
endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk (
  input logic clk,
  input logic rst,
  input logic frm_vld,
  input logic fifo_nfull,
  input logic dec_vld,
  input logic dec_acc,
  input logic st_wr
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !dec_vld && !dec_acc && !st_wr);
  p_dec_follows_r5: assert property (@(posedge clk) disable iff (rst) frm_vld |=> dec_vld);
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst) !frm_vld |=> !dec_vld);
  p_acc_needs_vld_r5: assert property (@(posedge clk) disable iff (rst) dec_acc |-> dec_vld);
  p_full_blocks_r6: assert property (@(posedge clk) disable iff (rst) !fifo_nfull |=> !st_wr);
  p_store_accepted_r6: assert property (@(posedge clk) disable iff (rst) st_wr |-> dec_vld && dec_acc);
  p_reject_no_store_r7: assert property (@(posedge clk) disable iff (rst) dec_vld && !dec_acc |-> !st_wr);
endmodule

bind can_accept_filter can_accept_filter_chk u_chk (
  .clk(clk), .rst(rst), .frm_vld(frm_vld), .fifo_nfull(fifo_nfull),
  .dec_vld(dec_vld), .dec_acc(dec_acc), .st_wr(st_wr)
);

// File: tb/tb_can_accept_filter.sv
module tb_can_accept_filter;
  import can_flt_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 20000;
  localparam int NVEC = 10;
  // vector: {ide, rtr, id[28:0], nfull, exp_acc}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 29'h123,       1'b1, 1'b1},
    {1'b0, 1'b0, 29'h124,       1'b1, 1'b0},
    {1'b1, 1'b0, 29'h123,       1'b1, 1'b0},
    {1'b1, 1'b0, 29'h0ABCDE55,  1'b1, 1'b1},
    {1'b1, 1'b0, 29'h0ABCDF55,  1'b1, 1'b0},
    {1'b0, 1'b1, 29'h7FF,       1'b1, 1'b1},
    {1'b1, 1'b1, 29'h1,         1'b1, 1'b1},
    {1'b0, 1'b0, 29'h123,       1'b0, 1'b1},
    {1'b0, 1'b0, 29'h0,         1'b1, 1'b0},
    {1'b1, 1'b1, 29'h0ABCDE00,  1'b1, 1'b1}
  };

  logic clk = 0, rst = 1;
  logic frm_vld = 0, frm_ide = 0, frm_rtr = 0, fifo_nfull = 1;
  logic [ID_W-1:0] frm_id = '0;
  logic cfg_wr = 0, cfg_sel = 0, en_wr = 0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [KEY_W-1:0] cfg_wdata = '0;
  logic [MAX_FLT-1:0] en_wdata = '0;
  logic dec_vld, dec_acc, st_wr, nf_vld, nf_acc, nf_st;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_accept_filter #(.NUM_FLT(4)) dut (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm_id(frm_id), .frm_ide(frm_ide),
    .frm_rtr(frm_rtr), .fifo_nfull(fifo_nfull), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .en_wr(en_wr), .en_wdata(en_wdata),
    .dec_vld(dec_vld), .dec_acc(dec_acc), .st_wr(st_wr)
  );

  can_accept_filter #(.NUM_FLT(0)) dut_nf (
    .clk(clk), .rst(rst), .frm_vld(frm_vld), .frm_id(frm_id), .frm_ide(frm_ide),
    .frm_rtr(frm_rtr), .fifo_nfull(fifo_nfull), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .en_wr(en_wr), .en_wdata(en_wdata),
    .dec_vld(nf_vld), .dec_acc(nf_acc), .st_wr(nf_st)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {vld,acc,st} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input int idx, input logic sel, input logic [KEY_W-1:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_idx = IDX_W'(idx); cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic wr_en(input logic [MAX_FLT-1:0] e);
    @(negedge clk);
    en_wr = 1; en_wdata = e;
    @(negedge clk);
    en_wr = 0;
  endtask

  // drives a strobe for one cycle; outputs are sampled at the next negedge
  task automatic send(input logic ide, input logic rtr, input logic [ID_W-1:0] id,
                      input logic nf, input string req, input logic exp_acc);
    @(negedge clk);
    frm_vld = 1; frm_ide = ide; frm_rtr = rtr; frm_id = id; fifo_nfull = nf;
    @(negedge clk);
    frm_vld = 0; fifo_nfull = 1;
    chk(req, {dec_vld, dec_acc, st_wr}, {1'b1, exp_acc, exp_acc & nf});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset outputs", {dec_vld, dec_acc, st_wr}, 3'b000);
    // R1 / R4: after reset all filters disabled, so any frame accepted
    send(1'b1, 1'b0, 29'h1555, 1'b1, "R1 R4 reset enables zero", 1'b1);

    // configure: f0 exact std 0x123; f1 extended 0x0ABCDExx data; f2 unused; f3 any remote
    wr_cfg(0, 0, {2'b11, {ID_W{1'b1}}});
    wr_cfg(0, 1, make_key(1'b0, 1'b0, 29'h123));
    wr_cfg(1, 0, {2'b11, 29'h1FFFFF00});
    wr_cfg(1, 1, make_key(1'b1, 1'b0, 29'h0ABCDE00));
    wr_cfg(2, 0, '0);
    wr_cfg(3, 0, make_key(1'b0, 1'b1, 29'h0));
    wr_cfg(3, 1, make_key(1'b0, 1'b1, 29'h0));
    wr_en(4'b1011);

    // table walk: R2 masked compare, R3 OR, R6 store gating, R7 reject, R10 flags
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][32], VEC[i][31], VEC[i][30:2], VEC[i][1],
           "R2 R3 R6 R7 R10 vector", VEC[i][0]);
    end

    // R8: write to enabled filter 0 ignored
    wr_cfg(0, 1, make_key(1'b0, 1'b0, 29'h456));
    send(1'b0, 1'b0, 29'h123, 1'b1, "R8 write to enabled ignored (old id)", 1'b1);
    send(1'b0, 1'b0, 29'h456, 1'b1, "R8 write to enabled ignored (new id)", 1'b0);

    // R8: disable f0, rewrite, re-enable
    wr_en(4'b1010);
    wr_cfg(0, 1, make_key(1'b0, 1'b0, 29'h456));
    wr_en(4'b1011);
    send(1'b0, 1'b0, 29'h456, 1'b1, "R8 rewrite after disable", 1'b1);
    send(1'b0, 1'b0, 29'h123, 1'b1, "R8 old id gone", 1'b0);

    // R9: enabling f2 (mask zero) accepts all
    wr_en(4'b0100);
    send(1'b1, 1'b0, 29'h1ABCDEF, 1'b1, "R9 f2 zero mask hits all", 1'b1);

    // R4: all disabled accepts all
    wr_en(4'b0000);
    send(1'b0, 1'b0, 29'h0, 1'b1, "R4 no filter enabled", 1'b1);

    // R5: back-to-back strobes, then idle
    wr_en(4'b0001);
    @(negedge clk);
    frm_vld = 1; frm_ide = 0; frm_rtr = 0; frm_id = 29'h456;
    @(negedge clk);
    chk("R5 back-to-back first", {dec_vld, dec_acc, st_wr}, 3'b111);
    frm_id = 29'h457;
    @(negedge clk);
    frm_vld = 0;
    chk("R5 back-to-back second", {dec_vld, dec_acc, st_wr}, 3'b100);
    @(negedge clk);
    chk("R5 idle after strobe", {dec_vld, dec_acc, st_wr}, 3'b000);

    // R4: zero-filter build accepts everything even with all enables written
    wr_en(4'b1111);
    wr_cfg(0, 0, '1);
    @(negedge clk);
    frm_vld = 1; frm_ide = 1; frm_rtr = 1; frm_id = 29'h1FFFFFFF;
    @(negedge clk);
    frm_vld = 0;
    chk("R4 NUM_FLT=0 accepts", {nf_vld, nf_acc, nf_st}, 3'b111);

    // R1: reset mid-run clears enables and outputs
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 reset again", {dec_vld, dec_acc, st_wr}, 3'b000);
    send(1'b0, 1'b0, 29'h999, 1'b1, "R1 enables cleared", 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule